// File: doc/BRIEF.md
# Split Nibble Register File

This block stores eight 4-bit registers and exposes them through two views at once. The narrow view offers eight read ports and eight write ports. Each port carries a one-hot or multi-hot enable vector with one bit per register, instead of a binary address. The wide view offers one read port and one write port that move all eight nibbles together as a single 32-bit word.

Writes from either view commit on the rising clock edge. Reads are combinational. A read that selects a register being written in the same cycle returns the value that is about to be stored, so a consumer never sees stale data.

When several writers target one nibble in the same cycle, a fixed priority decides the winner. A narrow port beats the wide port. Among narrow ports, the one with the highest index wins. The same resolved value feeds both the storage and every forwarding path.

Top module: `split_nibble_rf`

## Requirements
- R1: While reset is asserted (asynchronous, active low), all eight registers clear to zero. After release they read as zero until written.
- R2: A narrow read port returns the bitwise OR of every register whose bit is set in its enable vector (bit i selects register i). It returns zero when no bit is set.
- R3: A narrow write port p stores `nw_wdata[p]` into every register whose bit is set in `nw_wen[p]`, at the next rising clock edge. The stored value is not visible before that edge except through forwarding.
- R4: When `wd_ren` is high, the wide read port returns register i on bits [4*i+3:4*i]. When `wd_ren` is low, it returns zero.
- R5: When `wd_wen` is high, bits [4*i+3:4*i] of `wd_wdata` are stored into register i for all eight registers at the next rising edge.
- R6: A narrow read that selects a register being written in the same cycle uses the resolved write value for that register in place of the stored one.
- R7: The wide read forwards same-cycle writes nibble by nibble. Each written nibble shows its resolved write value, and every other nibble shows its stored value.
- R8: If a narrow write port and the wide write port target the same register in one cycle, the narrow port's data is stored and forwarded.
- R9: If several narrow write ports target the same register in one cycle, the data of the highest-numbered port is stored and forwarded.
- R10: A register that no port writes in a cycle keeps its value across the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| nr_ren | input | 8x8 | Narrow read enables, one vector per port, bit i selects register i |
| nr_rdata | output | 8x4 | Narrow read data per port |
| nw_wen | input | 8x8 | Narrow write enables, one vector per port |
| nw_wdata | input | 8x4 | Narrow write data per port |
| wd_ren | input | 1 | Wide read enable |
| wd_rdata | output | 32 | Wide read data, register i on bits [4*i+3:4*i] |
| wd_wen | input | 1 | Wide write enable, loads all registers |
| wd_wdata | input | 32 | Wide write data |

## Verification
Writes and reads of the same register can fall in the same cycle, and so can narrow writes and a wide write to the same nibble. Random cycles enable narrow reads, narrow writes and the wide write together. Directed cycles place a narrow write and a wide write on one nibble, and several narrow ports on one register. Each combinational output is compared, just before the edge, with a bench model that resolves priority and forwarding from the requirements. A wide read taken in the following idle cycle then shows which writer reached storage.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  localparam int NRF_REGS_DEF  = 8;
  localparam int NRF_NIB_DEF   = 4;
  localparam int NRF_PORTS_DEF = 8;
  localparam int NRF_WIDE_DEF  = NRF_REGS_DEF * NRF_NIB_DEF;
endpackage

// File: rtl/nrf_wr_arb.sv
module nrf_wr_arb #(
  parameter int NREGS  = 8,
  parameter int NIBW   = 4,
  parameter int NPORTS = 8,
  localparam int WIDEW = NREGS * NIBW
) (
  input  logic [NPORTS-1:0][NREGS-1:0] nw_wen,
  input  logic [NPORTS-1:0][NIBW-1:0]  nw_wdata,
  input  logic                         wd_wen,
  input  logic [WIDEW-1:0]             wd_wdata,
  output logic [NREGS-1:0]             wr_hit,
  output logic [NREGS-1:0][NIBW-1:0]   wr_val
);
  // per register: wide write is lowest priority, later narrow ports override
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_comb begin
      wr_hit[r] = wd_wen;
      wr_val[r] = wd_wen ? wd_wdata[r*NIBW +: NIBW] : '0;
      for (int p = 0; p < NPORTS; p++) begin
        if (nw_wen[p][r]) begin
          wr_hit[r] = 1'b1;
          wr_val[r] = nw_wdata[p];
        end
      end
    end
  end
endmodule

// File: rtl/nrf_store.sv
module nrf_store #(
  parameter int NREGS = 8,
  parameter int NIBW  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREGS-1:0]           wr_hit,
  input  logic [NREGS-1:0][NIBW-1:0] wr_val,
  output logic [NREGS-1:0][NIBW-1:0] q
);
  logic [NREGS-1:0][NIBW-1:0] q_nxt;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_comb begin
      q_nxt[r] = wr_val[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[r] <= '0;
      end else if (wr_hit[r]) begin
        q[r] <= q_nxt[r];
      end
    end
  end
endmodule

// File: rtl/nrf_rd_net.sv
module nrf_rd_net #(
  parameter int NREGS  = 8,
  parameter int NIBW   = 4,
  parameter int NPORTS = 8,
  localparam int WIDEW = NREGS * NIBW
) (
  input  logic [NREGS-1:0][NIBW-1:0]   q,
  input  logic [NREGS-1:0]             wr_hit,
  input  logic [NREGS-1:0][NIBW-1:0]   wr_val,
  input  logic [NPORTS-1:0][NREGS-1:0] nr_ren,
  input  logic                         wd_ren,
  output logic [NPORTS-1:0][NIBW-1:0]  nr_rdata,
  output logic [WIDEW-1:0]             wd_rdata
);
  logic [NREGS-1:0][NIBW-1:0] fwd;

  // write-through: resolved write value replaces the stored one
  for (genvar r = 0; r < NREGS; r++) begin : g_fwd
    always_comb begin
      fwd[r] = wr_hit[r] ? wr_val[r] : q[r];
    end
    always_comb begin
      wd_rdata[r*NIBW +: NIBW] = wd_ren ? fwd[r] : '0;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_comb begin
      nr_rdata[p] = '0;
      for (int r = 0; r < NREGS; r++) begin
        if (nr_ren[p][r]) begin
          nr_rdata[p] = nr_rdata[p] | fwd[r];
        end
      end
    end
  end
endmodule

// File: rtl/split_nibble_rf.sv
module split_nibble_rf #(
  parameter int NREGS  = nrf_pkg::NRF_REGS_DEF,
  parameter int NIBW   = nrf_pkg::NRF_NIB_DEF,
  parameter int NPORTS = nrf_pkg::NRF_PORTS_DEF,
  localparam int WIDEW = NREGS * NIBW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORTS-1:0][NREGS-1:0] nr_ren,
  output logic [NPORTS-1:0][NIBW-1:0]  nr_rdata,
  input  logic [NPORTS-1:0][NREGS-1:0] nw_wen,
  input  logic [NPORTS-1:0][NIBW-1:0]  nw_wdata,
  input  logic                         wd_ren,
  output logic [WIDEW-1:0]             wd_rdata,
  input  logic                         wd_wen,
  input  logic [WIDEW-1:0]             wd_wdata
);
  logic [NREGS-1:0]           wr_hit;
  logic [NREGS-1:0][NIBW-1:0] wr_val;
  logic [NREGS-1:0][NIBW-1:0] q;

  nrf_wr_arb #(.NREGS(NREGS), .NIBW(NIBW), .NPORTS(NPORTS)) u_arb (
    .nw_wen   (nw_wen),
    .nw_wdata (nw_wdata),
    .wd_wen   (wd_wen),
    .wd_wdata (wd_wdata),
    .wr_hit   (wr_hit),
    .wr_val   (wr_val)
  );

  nrf_store #(.NREGS(NREGS), .NIBW(NIBW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wr_val (wr_val),
    .q      (q)
  );

  nrf_rd_net #(.NREGS(NREGS), .NIBW(NIBW), .NPORTS(NPORTS)) u_rd (
    .q        (q),
    .wr_hit   (wr_hit),
    .wr_val   (wr_val),
    .nr_ren   (nr_ren),
    .wd_ren   (wd_ren),
    .nr_rdata (nr_rdata),
    .wd_rdata (wd_rdata)
  );
endmodule

// File: rtl/nrf_checker.sv
module nrf_checker #(
  parameter int NREGS  = 8,
  parameter int NIBW   = 4,
  parameter int NPORTS = 8,
  localparam int WIDEW = NREGS * NIBW
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NPORTS-1:0][NREGS-1:0] nr_ren,
  input logic [NPORTS-1:0][NIBW-1:0]  nr_rdata,
  input logic [NPORTS-1:0][NREGS-1:0] nw_wen,
  input logic [NPORTS-1:0][NIBW-1:0]  nw_wdata,
  input logic                         wd_ren,
  input logic [WIDEW-1:0]             wd_rdata,
  input logic                         wd_wen,
  input logic [WIDEW-1:0]             wd_wdata
);
  logic [NREGS-1:0][NPORTS-1:0] col;
  logic                         any_nw;

  always_comb begin
    any_nw = |nw_wen;
    for (int r = 0; r < NREGS; r++) begin
      for (int p = 0; p < NPORTS; p++) begin
        col[r][p] = nw_wen[p][r];
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_np
    assert_idle_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (nr_ren[p] == '0) |-> (nr_rdata[p] == '0));
  end

  assert_wide_off_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_ren |-> (wd_rdata == '0));

  assert_wide_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_wen && !any_nw) |=> (!wd_ren || wd_wen || any_nw || (wd_rdata == $past(wd_wdata))));

  for (genvar r = 0; r < NREGS; r++) begin : g_nib
    assert_wide_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_ren && wd_wen && (col[r] == '0)) |->
        (wd_rdata[r*NIBW +: NIBW] == wd_wdata[r*NIBW +: NIBW]));

    assert_narrow_over_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_ren && wd_wen && col[r][0] && ($countones(col[r]) == 1)) |->
        (wd_rdata[r*NIBW +: NIBW] == nw_wdata[0]));

    assert_top_port_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_ren && col[r][NPORTS-1]) |->
        (wd_rdata[r*NIBW +: NIBW] == nw_wdata[NPORTS-1]));
  end
endmodule

bind split_nibble_rf nrf_checker #(.NREGS(NREGS), .NIBW(NIBW), .NPORTS(NPORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .nr_ren   (nr_ren),
  .nr_rdata (nr_rdata),
  .nw_wen   (nw_wen),
  .nw_wdata (nw_wdata),
  .wd_ren   (wd_ren),
  .wd_rdata (wd_rdata),
  .wd_wen   (wd_wen),
  .wd_wdata (wd_wdata)
);

// File: tb/split_nibble_rf_tb.sv
`timescale 1ns/1ps
module split_nibble_rf_tb;
  localparam int NR = 8;
  localparam int NB = 4;
  localparam int NP = 8;
  localparam int WW = NR * NB;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NP-1:0][NR-1:0] nr_ren;
  logic [NP-1:0][NB-1:0] nr_rdata;
  logic [NP-1:0][NR-1:0] nw_wen;
  logic [NP-1:0][NB-1:0] nw_wdata;
  logic                 wd_ren;
  logic [WW-1:0]        wd_rdata;
  logic                 wd_wen;
  logic [WW-1:0]        wd_wdata;

  logic [NB-1:0] mdl [NR];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  split_nibble_rf u_dut (
    .clk(clk), .rst_n(rst_n),
    .nr_ren(nr_ren), .nr_rdata(nr_rdata),
    .nw_wen(nw_wen), .nw_wdata(nw_wdata),
    .wd_ren(wd_ren), .wd_rdata(wd_rdata),
    .wd_wen(wd_wen), .wd_wdata(wd_wdata)
  );

  // resolved write per register: wide lowest, highest narrow port highest
  function automatic bit wr_on(int r);
    bit h = wd_wen;
    for (int p = 0; p < NP; p++) if (nw_wen[p][r]) h = 1'b1;
    return h;
  endfunction

  function automatic logic [NB-1:0] wr_data(int r);
    logic [NB-1:0] v = wd_wdata[r*NB +: NB];
    for (int p = 0; p < NP; p++) if (nw_wen[p][r]) v = nw_wdata[p];
    return v;
  endfunction

  function automatic logic [NB-1:0] seen(int r);
    return wr_on(r) ? wr_data(r) : mdl[r];
  endfunction

  task automatic chk(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    nr_ren = '0; nw_wen = '0; nw_wdata = '0;
    wd_ren = 1'b0; wd_wen = 1'b0; wd_wdata = '0;
  endtask

  // compare all outputs against the model, then advance one edge
  task automatic step();
    logic [NB-1:0] e;
    logic [WW-1:0] ew;
    bit coll;
    #1;
    for (int p = 0; p < NP; p++) begin
      e = '0; coll = 1'b0;
      for (int r = 0; r < NR; r++) if (nr_ren[p][r]) begin
        e = e | seen(r);
        if (wr_on(r)) coll = 1'b1;
      end
      chk(coll ? "R6 narrow forward" : "R2 narrow read", {28'd0, nr_rdata[p]}, {28'd0, e});
    end
    ew = '0;
    coll = 1'b0;
    for (int r = 0; r < NR; r++) begin
      if (wd_ren) ew[r*NB +: NB] = seen(r);
      if (wr_on(r)) coll = 1'b1;
    end
    chk(coll ? "R7 wide forward" : "R4 wide read", wd_rdata, ew);
    @(posedge clk);
    for (int r = 0; r < NR; r++) if (wr_on(r)) mdl[r] = wr_data(r);
    @(negedge clk);
  endtask

  // idle cycle with wide read, checking storage
  task automatic wide_look(string tag);
    logic [WW-1:0] ew;
    idle_inputs();
    wd_ren = 1'b1;
    #1;
    for (int r = 0; r < NR; r++) ew[r*NB +: NB] = mdl[r];
    chk(tag, wd_rdata, ew);
    step();
  endtask

  function automatic logic [NR-1:0] rand_en(int dens);
    logic [NR-1:0] v;
    int k = $urandom % dens;
    if (k == 0) v = NR'($urandom);
    else if (k == 1) v = NR'(1) << ($urandom % NR);
    else v = '0;
    return v;
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    for (int r = 0; r < NR; r++) mdl[r] = '0;
    rst_n = 1'b0;
    // drive non-zero write before release; reset must win
    wd_wen = 1'b1; wd_wdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    idle_inputs();
    wd_ren = 1'b1;
    #1 chk("R1 reset clear", wd_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    wide_look("R1 zero after release");

    // R5 wide write then look
    idle_inputs(); wd_wen = 1'b1; wd_wdata = 32'h7654_3210; step();
    wide_look("R5 wide store");

    // R3 multi-hot narrow write
    idle_inputs(); nw_wen[2] = 8'b1010_0101; nw_wdata[2] = 4'hC; step();
    wide_look("R3 multi-hot narrow store");

    // R10 untouched registers hold across edges
    idle_inputs(); nw_wen[5] = 8'b0000_0010; nw_wdata[5] = 4'h9; step();
    idle_inputs(); step();
    wide_look("R10 hold");

    // R8 narrow vs wide on register 3, forwarding visible on all ports
    idle_inputs();
    wd_wen = 1'b1; wd_wdata = 32'hAAAA_AAAA;
    nw_wen[0] = 8'b0000_1000; nw_wdata[0] = 4'h5;
    wd_ren = 1'b1; nr_ren[1] = 8'b0000_1000; nr_ren[4] = 8'b0001_0000;
    step();
    wide_look("R8 narrow beats wide");

    // R9 three narrow ports on register 6
    idle_inputs();
    nw_wen[1] = 8'b0100_0000; nw_wdata[1] = 4'h1;
    nw_wen[6] = 8'b0100_0000; nw_wdata[6] = 4'hE;
    nw_wen[3] = 8'b0100_0001; nw_wdata[3] = 4'h3;
    nr_ren[7] = 8'b0100_0001; wd_ren = 1'b1;
    step();
    wide_look("R9 highest port wins");

    // R2 multi-hot OR read with no writes
    idle_inputs();
    for (int p = 0; p < NP; p++) nr_ren[p] = NR'(8'hFF >> p);
    step();

    // random mix
    for (int c = 0; c < 3000; c++) begin
      idle_inputs();
      for (int p = 0; p < NP; p++) begin
        nr_ren[p]   = rand_en(3);
        nw_wen[p]   = rand_en(6);
        nw_wdata[p] = NB'($urandom);
      end
      wd_ren   = ($urandom % 2) == 0;
      wd_wen   = ($urandom % 6) == 0;
      wd_wdata = $urandom;
      step();
      if ((c % 50) == 49) wide_look("R10 random storage");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule